// File: doc/BRIEF.md
# Dual-Mode Message Queue Status Tracker

This block follows the fill level and the event history of one message queue inside a bus controller. A single mode input sets whether the queue acts as a transmit queue, which software fills and the bus drains, or as a receive buffer, which the bus fills and software drains. The block does not store any messages. It counts the messages held, up to a depth set by a 5-bit size field. It also keeps a zero-based index of the next slot. In transmit mode that slot is the next message to be sent. In receive mode it is the slot where the next incoming message will be written.

From the one occupancy count the block derives three level flags. Their meaning and polarity change with the mode. The block also captures the result of each transmission (aborted, lost arbitration, bus error) and holds two sticky error flags until software clears them. All of this is read as one 16-bit status word. Reading it has a side effect: it clears the abort bit.

Top module: `msgq_status_tracker`

## Requirements
- R1: While `rst_n` is low, status bits 12:3 read 0, and bits 2:0 reflect an empty queue in the selected mode.
- R2: The index in status bits 12:8 starts at 0 and advances by one on each accepted pop in transmit mode, or on each accepted push in receive mode. After it reaches `size_m1` it returns to 0.
- R3: Depth is `size_m1`+1. A push is accepted only when occupancy is below depth, and a pop only when occupancy is above 0. A push at full is dropped and occupancy does not change.
- R4: With `tx_mode`=1, bit 2 is 1 when the queue is empty, bit 1 is 1 when occupancy <= floor(depth/2), and bit 0 is 1 when the queue is not full.
- R5: With `tx_mode`=0, bit 2 is 1 when the queue is full, bit 1 is 1 when occupancy >= floor(depth/2), and bit 0 is 1 when the queue is not empty.
- R6: A receive-mode push while full, with no `q_reset`, sets a sticky overflow flag. The flag reads on bit 3 in receive mode and reads as 0 in transmit mode.
- R7: `attempts_out` in transmit mode sets a sticky flag. The flag reads on bit 4 in transmit mode and reads as 0 in receive mode.
- R8: `clr_stb` clears the sticky flags selected by `clr_mask` (bit 0 = overflow, bit 1 = attempts). A hardware set in the same cycle wins over the clear.
- R9: A completion event (`done_ok` or `done_abort`) loads bit 7 from `done_abort`, bit 6 from `arb_lost` and bit 5 from `bus_err`. Otherwise these bits hold.
- R10: `rd_stb` or `tx_req` clears bit 7 only. A completion event in the same cycle takes precedence.
- R11: `q_reset` sets occupancy, the index and bits 7:5 to 0, and leaves the sticky flags unchanged.
- R12: Status bits 15:13 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mode | input | 1 | 1 = transmit queue, 0 = receive buffer |
| size_m1 | input | 5 | Queue depth minus one |
| q_reset | input | 1 | Queue reset strobe |
| push | input | 1 | Message written into the queue |
| pop | input | 1 | Message taken from the queue |
| done_ok | input | 1 | Transmission completed |
| done_abort | input | 1 | Transmission aborted |
| arb_lost | input | 1 | Arbitration was lost during the finished message |
| bus_err | input | 1 | Bus error during the finished message |
| tx_req | input | 1 | New transmit request strobe |
| rd_stb | input | 1 | Status word read strobe |
| clr_stb | input | 1 | Sticky flag clear strobe |
| clr_mask | input | 2 | Selects which sticky flags to clear |
| attempts_out | input | 1 | Transmit attempts exhausted event |
| status | output | 16 | Status word |

## Verification
Every stored field (index, outcome bits, sticky flags, occupancy) changes on the clock edge that samples the stimulus. The new value is therefore visible on `status` one cycle later. The level flags and the mode masking also follow `tx_mode` and `size_m1` combinationally, with no delay. The bench drives inputs on the falling edge and updates its reference model on the rising edge. It compares each status field 3 ns after that rising edge, so every comparison sees the result of exactly one edge. Directed checks are taken on the falling edge that follows the pulse, before the next input change.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  localparam int SIZE_W = 5;
  localparam int OCC_W  = SIZE_W + 1;
  localparam int STICKY_N = 2;

  typedef logic [SIZE_W-1:0] idx_t;
  typedef logic [OCC_W-1:0]  occ_t;

  // Number of messages the queue holds for a given size field.
  function automatic occ_t depth_of(idx_t sz);
    return {1'b0, sz} + occ_t'(1);
  endfunction

  // Half-level threshold, rounded down.
  function automatic occ_t half_of(idx_t sz);
    return depth_of(sz) >> 1;
  endfunction

  // Zero-based index step that wraps after the last slot.
  function automatic idx_t next_idx(idx_t cur, idx_t sz);
    return (cur >= sz) ? '0 : cur + idx_t'(1);
  endfunction

  // Level flags {b2, b1, b0} for the given direction.
  function automatic logic [2:0] level_flags(logic tx, occ_t occ, idx_t sz);
    occ_t d;
    occ_t h;
    d = depth_of(sz);
    h = half_of(sz);
    if (tx) return {occ == '0, occ <= h, occ < d};
    else    return {occ >= d, occ >= h, occ != '0};
  endfunction
endpackage

// File: rtl/msgq_occ_ctr.sv
module msgq_occ_ctr
  import msgq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic q_reset,
  input  logic tx_mode,
  input  idx_t size_m1,
  input  logic push,
  input  logic pop,
  output occ_t occ_q,
  output idx_t idx_q,
  output logic pop_ok,
  output logic ovf_evt
);
  occ_t depth;
  logic full, empty, push_ok, adv;

  always_comb begin
    depth   = depth_of(size_m1);
    full    = occ_q >= depth;
    empty   = occ_q == '0;
    push_ok = push && !full;
    pop_ok  = pop && !empty;
    ovf_evt = !tx_mode && push && full && !q_reset;
    adv     = tx_mode ? pop_ok : push_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      idx_q <= '0;
    end else if (q_reset) begin
      occ_q <= '0;
      idx_q <= '0;
    end else begin
      occ_q <= occ_q + occ_t'(push_ok) - occ_t'(pop_ok);
      if (adv) idx_q <= next_idx(idx_q, size_m1);
    end
  end
endmodule

// File: rtl/msgq_level_flags.sv
module msgq_level_flags
  import msgq_pkg::*;
(
  input  logic       tx_mode,
  input  idx_t       size_m1,
  input  occ_t       occ,
  output logic [2:0] lvl
);
  assign lvl = level_flags(tx_mode, occ, size_m1);
endmodule

// File: rtl/msgq_event_flags.sv
module msgq_event_flags
  import msgq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                q_reset,
  input  logic                tx_mode,
  input  logic                done_ok,
  input  logic                done_abort,
  input  logic                arb_lost,
  input  logic                bus_err,
  input  logic                tx_req,
  input  logic                rd_stb,
  input  logic                clr_stb,
  input  logic [STICKY_N-1:0] clr_mask,
  input  logic                attempts_out,
  input  logic                ovf_evt,
  output logic                done_evt,
  output logic [2:0]          out_q,
  output logic [STICKY_N-1:0] sticky_q
);
  logic [STICKY_N-1:0] set_vec;

  assign done_evt = done_ok || done_abort;
  assign set_vec  = {tx_mode && attempts_out, ovf_evt};

  // {aborted, lost arbitration, bus error}
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              out_q <= '0;
    else if (q_reset)        out_q <= '0;
    else if (done_evt)       out_q <= {done_abort, arb_lost, bus_err};
    else if (rd_stb || tx_req) out_q[2] <= 1'b0;
  end

  for (genvar g = 0; g < STICKY_N; g++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         sticky_q[g] <= 1'b0;
      else if (set_vec[g])                sticky_q[g] <= 1'b1;
      else if (clr_stb && clr_mask[g])    sticky_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/msgq_status_tracker.sv
module msgq_status_tracker
  import msgq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_mode,
  input  logic [4:0]  size_m1,
  input  logic        q_reset,
  input  logic        push,
  input  logic        pop,
  input  logic        done_ok,
  input  logic        done_abort,
  input  logic        arb_lost,
  input  logic        bus_err,
  input  logic        tx_req,
  input  logic        rd_stb,
  input  logic        clr_stb,
  input  logic [1:0]  clr_mask,
  input  logic        attempts_out,
  output logic [15:0] status
);
  localparam int PAD_W = 16 - SIZE_W - 8;

  occ_t                occ_q;
  idx_t                idx_q;
  logic                pop_ok, ovf_evt, done_evt;
  logic [2:0]          lvl, out_q;
  logic [STICKY_N-1:0] sticky_q;

  msgq_occ_ctr u_occ (
    .clk(clk), .rst_n(rst_n), .q_reset(q_reset), .tx_mode(tx_mode),
    .size_m1(size_m1), .push(push), .pop(pop), .occ_q(occ_q),
    .idx_q(idx_q), .pop_ok(pop_ok), .ovf_evt(ovf_evt)
  );

  msgq_level_flags u_lvl (
    .tx_mode(tx_mode), .size_m1(size_m1), .occ(occ_q), .lvl(lvl)
  );

  msgq_event_flags u_evt (
    .clk(clk), .rst_n(rst_n), .q_reset(q_reset), .tx_mode(tx_mode),
    .done_ok(done_ok), .done_abort(done_abort), .arb_lost(arb_lost),
    .bus_err(bus_err), .tx_req(tx_req), .rd_stb(rd_stb),
    .clr_stb(clr_stb), .clr_mask(clr_mask), .attempts_out(attempts_out),
    .ovf_evt(ovf_evt), .done_evt(done_evt), .out_q(out_q),
    .sticky_q(sticky_q)
  );

  assign status = {{PAD_W{1'b0}}, idx_q, out_q,
                   sticky_q[1] && tx_mode, sticky_q[0] && !tx_mode, lvl};
endmodule

// File: rtl/msgq_status_chk.sv
module msgq_status_chk
  import msgq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        tx_mode,
  input logic        q_reset,
  input logic        rd_stb,
  input logic        tx_req,
  input logic        clr_stb,
  input logic [1:0]  clr_mask,
  input logic        done_evt,
  input logic        ovf_evt,
  input logic        pop_ok,
  input occ_t        occ,
  input idx_t        idx,
  input logic        ovf_q,
  input logic [15:0] status
);
  assert_drop_at_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !pop_ok) |=> $stable(occ));

  assert_ovf_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_q);

  assert_ovf_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode |-> !status[3]);

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && clr_stb && clr_mask[0]) |=> ovf_q);

  assert_read_clears_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_stb || tx_req) && !done_evt) |=> !status[7]);

  assert_qreset_zeroes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    q_reset |=> (occ == '0 && idx == '0 && status[7:5] == 3'b000));

  assert_pad_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    status[15:13] == 3'b000);
endmodule

bind msgq_status_tracker msgq_status_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .q_reset(q_reset),
  .rd_stb(rd_stb), .tx_req(tx_req), .clr_stb(clr_stb), .clr_mask(clr_mask),
  .done_evt(done_evt), .ovf_evt(ovf_evt), .pop_ok(pop_ok), .occ(occ_q),
  .idx(idx_q), .ovf_q(sticky_q[0]), .status(status)
);

// File: tb/msgq_status_tracker_tb_top.sv
`timescale 1ns/1ps
module msgq_status_tracker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_mode = 1'b1;
  logic [4:0] size_m1 = 5'd3;
  logic q_reset = 0, push = 0, pop = 0, done_ok = 0, done_abort = 0;
  logic arb_lost = 0, bus_err = 0, tx_req = 0, rd_stb = 0, clr_stb = 0;
  logic [1:0] clr_mask = 2'b00;
  logic attempts_out = 0;
  logic [15:0] status;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  int m_occ = 0, m_idx = 0;
  int m_abt = 0, m_larb = 0, m_err = 0, m_ovf = 0, m_ats = 0;

  always #5 clk = ~clk;

  msgq_status_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .size_m1(size_m1),
    .q_reset(q_reset), .push(push), .pop(pop), .done_ok(done_ok),
    .done_abort(done_abort), .arb_lost(arb_lost), .bus_err(bus_err),
    .tx_req(tx_req), .rd_stb(rd_stb), .clr_stb(clr_stb),
    .clr_mask(clr_mask), .attempts_out(attempts_out), .status(status)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    q_reset = 0; push = 0; pop = 0; done_ok = 0; done_abort = 0;
    arb_lost = 0; bus_err = 0; tx_req = 0; rd_stb = 0; clr_stb = 0;
    clr_mask = 2'b00; attempts_out = 0;
  endtask

  function automatic int exp_level(int tx, int occ, int sz);
    int depth, half;
    depth = sz + 1;
    half = depth / 2;
    if (tx != 0)
      return ((occ == 0) ? 4 : 0) + ((occ <= half) ? 2 : 0) + ((occ < depth) ? 1 : 0);
    return ((occ >= depth) ? 4 : 0) + ((occ >= half) ? 2 : 0) + ((occ != 0) ? 1 : 0);
  endfunction

  // reference model update, then per-cycle field comparison
  always @(posedge clk) begin
    int depth;
    depth = int'(size_m1) + 1;
    if (!rst_n) begin
      m_occ = 0; m_idx = 0; m_abt = 0; m_larb = 0; m_err = 0; m_ovf = 0; m_ats = 0;
    end else begin
      bit pa, po;
      pa = push && (m_occ < depth);
      po = pop && (m_occ > 0);
      if (!tx_mode && push && m_occ >= depth && !q_reset) m_ovf = 1;
      else if (clr_stb && clr_mask[0]) m_ovf = 0;
      if (tx_mode && attempts_out) m_ats = 1;
      else if (clr_stb && clr_mask[1]) m_ats = 0;
      if (q_reset) begin
        m_occ = 0; m_idx = 0; m_abt = 0; m_larb = 0; m_err = 0;
      end else begin
        m_occ = m_occ + int'(pa) - int'(po);
        if ((tx_mode && po) || (!tx_mode && pa))
          m_idx = (m_idx + 1) % depth;
        if (done_ok || done_abort) begin
          m_abt = int'(done_abort); m_larb = int'(arb_lost); m_err = int'(bus_err);
        end else if (rd_stb || tx_req) m_abt = 0;
      end
    end
    #3;
    if (!finished) begin
      chk("R2 index", int'(status[12:8]), m_idx);
      chk("R9 outcome", int'(status[7:5]), m_abt * 4 + m_larb * 2 + m_err);
      chk("R7 attempts", int'(status[4]), tx_mode ? m_ats : 0);
      chk("R6 overflow", int'(status[3]), tx_mode ? 0 : m_ovf);
      chk(tx_mode ? "R4 tx levels" : "R5 rx levels", int'(status[2:0]),
          exp_level(int'(tx_mode), m_occ, int'(size_m1)));
      chk("R12 pad", int'(status[15:13]), 0);
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset fields", int'(status[12:3]), 0);
    chk("R1 reset levels", int'(status[2:0]), 7);
    rst_n = 1;
    step();
    // transmit, depth 4
    for (int i = 0; i < 5; i++) begin push = 1; step(); end
    chk("R3 fifth push dropped", int'(status[2:0]), 0);
    pop = 1; step();
    chk("R2 tx index after pop", int'(status[12:8]), 1);
    for (int i = 0; i < 3; i++) begin pop = 1; step(); end
    chk("R2 tx index wrapped", int'(status[12:8]), 0);
    chk("R4 tx empty", int'(status[2:0]), 7);
    done_abort = 1; arb_lost = 1; step();
    chk("R9 abort load", int'(status[7:5]), 6);
    rd_stb = 1; step();
    chk("R10 read clears abort only", int'(status[7:5]), 2);
    done_ok = 1; bus_err = 1; step();
    chk("R9 completion load", int'(status[7:5]), 1);
    done_abort = 1; step();
    tx_req = 1; step();
    chk("R10 tx request clears abort", int'(status[7]), 0);
    done_abort = 1; rd_stb = 1; step();
    chk("R10 completion beats read", int'(status[7]), 1);
    attempts_out = 1; step();
    chk("R7 attempts set", int'(status[4]), 1);
    attempts_out = 1; clr_stb = 1; clr_mask = 2'b10; step();
    chk("R8 set beats clear", int'(status[4]), 1);
    clr_stb = 1; clr_mask = 2'b10; step();
    chk("R8 clear attempts", int'(status[4]), 0);
    attempts_out = 1; step();
    // receive, depth 5
    tx_mode = 0; size_m1 = 5'd4; q_reset = 1; step();
    chk("R7 attempts hidden in rx", int'(status[4]), 0);
    chk("R11 outcome cleared", int'(status[7:5]), 0);
    for (int i = 0; i < 5; i++) begin push = 1; step(); end
    chk("R5 rx full", int'(status[2:0]), 7);
    chk("R2 rx index wrapped", int'(status[12:8]), 0);
    push = 1; step();
    chk("R6 overflow set", int'(status[3]), 1);
    pop = 1; step();
    chk("R3 overflow push dropped", int'(status[2:0]), 3);
    push = 1; step();
    push = 1; clr_stb = 1; clr_mask = 2'b01; step();
    chk("R8 overflow set beats clear", int'(status[3]), 1);
    clr_stb = 1; clr_mask = 2'b01; step();
    chk("R8 overflow cleared", int'(status[3]), 0);
    push = 1; step();
    q_reset = 1; step();
    chk("R11 sticky kept", int'(status[3]), 1);
    chk("R11 index zero", int'(status[12:8]), 0);
    chk("R11 rx empty", int'(status[2:0]), 0);
    tx_mode = 1; step();
    chk("R6 overflow hidden in tx", int'(status[3]), 0);
    size_m1 = 5'd0; q_reset = 1; step();
    push = 1; step();
    chk("R4 depth one full", int'(status[2:0]), 0);
    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 60) == 0) begin
        q_reset = 1; tx_mode = 1'($urandom_range(0, 1));
        size_m1 = 5'($urandom_range(0, 31));
      end
      push = 1'($urandom_range(0, 2) != 0);
      pop = 1'($urandom_range(0, 2) == 0);
      done_ok = 1'($urandom_range(0, 9) == 0);
      done_abort = 1'($urandom_range(0, 12) == 0);
      arb_lost = 1'($urandom_range(0, 1));
      bus_err = 1'($urandom_range(0, 1));
      tx_req = 1'($urandom_range(0, 15) == 0);
      rd_stb = 1'($urandom_range(0, 7) == 0);
      clr_stb = 1'($urandom_range(0, 9) == 0);
      clr_mask = 2'($urandom_range(0, 3));
      attempts_out = 1'($urandom_range(0, 20) == 0);
      step();
    end
    @(posedge clk); #4;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule